// File: doc/BRIEF.md
# Shared-Stage Reservation Issue Checker

This block decides when a floating-point operation may enter an arithmetic unit in which the adder, multiplier and divider share sub-stages: unpack, operand shift, mantissa add, rounding, exception test, two multiplier stages and a divide stage. Each operation kind walks through a fixed sequence of stage sets, one set per cycle. The block keeps a table that records which stages are already claimed in each upcoming cycle. It accepts a new operation only when every stage set in that operation's sequence is free in the matching future cycle. When it accepts an operation, it adds that sequence to the table. The table advances by one cycle on every clock.

Operations arrive on a valid/ready stream. An operation that would collide is held off by a low `op_ready` and is tried again on every cycle until it fits. `op_ready` is computed from `op_kind` and the table alone, so it does not depend on `op_valid`. While `op_valid` is high and the operation has not yet been accepted, the producer must hold `op_valid` high and keep `op_kind` unchanged. An operation is accepted in a cycle where `op_valid` and `op_ready` are both high at the rising edge. The `stage_busy` output shows which stages are occupied in the current cycle. Operand data paths are not part of this block.

Top module: `fpx_stage_issue`

## Requirements
- R1: After reset, `stage_busy` is 0 and `op_ready` is 1 for every value of `op_kind`.
- R2: `op_kind` codes: 0 add/subtract, 1 multiply, 2 negate, 3 absolute value, 4 compare, 5 divide. Stage bits in `stage_busy`: bit0 unpack, bit1 shift, bit2 add, bit3 round, bit4 exception test, bit5 multiply-1, bit6 multiply-2, bit7 divide. Per-cycle sequences:
  - add: {0},{1,2},{2,3},{3,1}
  - multiply: {0},{4,5},{5},{5},{5},{6},{6,2},{3}
  - negate and absolute value: {0},{1}
  - compare: {0},{2},{3}
  - divide: {0},{2},{3}, then 27 cycles of {7}, then {7,2},{7,3},{7,2},{7,3},{2},{3}
- R3: `op_ready` is 1 exactly when, for every step k of the offered sequence, step k shares no stage with what is reserved for the cycle k+1 cycles ahead. A stalled operation is accepted in the first cycle in which this holds.
- R4: If an operation is accepted in cycle c, step k of its sequence appears in `stage_busy` in cycle c+1+k, ORed with the steps of all other accepted operations.
- R5: An add offered in the cycle after an accepted add is accepted 3 cycles after the first add.
- R6: A multiply offered in the cycle after an accepted multiply is accepted 4 cycles after the first multiply.
- R7: An add offered 1, 2 or 3 cycles after a multiply is accepted at once. An add offered 4 or 5 cycles after a multiply is accepted 6 cycles after the multiply.
- R8: Negate, absolute value and compare offered in the cycle after an operation of the same sequence are accepted at once. A compare offered in the cycle after an add waits one cycle.
- R9: A divide offered in the cycle after an accepted divide is accepted 32 cycles after the first divide.
- R10: Codes 6 and 7 are accepted at once and reserve no stage.
- R11: While `op_valid` is high and `op_ready` is low, `op_valid` stays high and `op_kind` stays stable in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is offered |
| op_kind | input | 3 | Operation code (see R2) |
| op_ready | output | 1 | The offered kind fits the table this cycle |
| stage_busy | output | 8 | Stages occupied in the current cycle |

## Verification
Two things can happen in the same clock: the table shifts forward by one cycle, and the sequence of a newly accepted operation is merged into it. To provoke this, a multiply is issued and an add follows in the very next cycle, while the multiply's sequence is still moving through the table. The result is judged on `stage_busy` over the following cycles. Its value must be the stage-by-stage OR of both sequences, each shifted to its own acceptance cycle, for example 0x31 and then 0x26. This shows that neither the shift nor the merge hides the other. The acceptance cycles of every stalled operation are also compared against the hand-derived collision gaps.

// File: rtl/fpx_issue_pkg.sv
package fpx_issue_pkg;

  localparam int NSTAGE    = 8;
  localparam int DIV_D_RUN = 27;
  localparam int PAT_LEN   = DIV_D_RUN + 9;

  typedef logic [NSTAGE-1:0] smask_t;

  localparam smask_t ST_U = 8'h01;
  localparam smask_t ST_S = 8'h02;
  localparam smask_t ST_A = 8'h04;
  localparam smask_t ST_R = 8'h08;
  localparam smask_t ST_E = 8'h10;
  localparam smask_t ST_M = 8'h20;
  localparam smask_t ST_N = 8'h40;
  localparam smask_t ST_D = 8'h80;

  typedef enum logic [2:0] {
    K_ADD  = 3'd0,
    K_MUL  = 3'd1,
    K_NEG  = 3'd2,
    K_ABS  = 3'd3,
    K_CMP  = 3'd4,
    K_DIV  = 3'd5,
    K_RSV6 = 3'd6,
    K_RSV7 = 3'd7
  } opk_t;

  // stage set used by operation kind k in step s of its walk
  function automatic smask_t step_mask(opk_t k, int unsigned s);
    smask_t m;
    m = '0;
    case (k)
      K_ADD: begin
        case (s)
          0: m = ST_U;
          1: m = ST_S | ST_A;
          2: m = ST_A | ST_R;
          3: m = ST_R | ST_S;
          default: m = '0;
        endcase
      end
      K_MUL: begin
        case (s)
          0: m = ST_U;
          1: m = ST_E | ST_M;
          2, 3, 4: m = ST_M;
          5: m = ST_N;
          6: m = ST_N | ST_A;
          7: m = ST_R;
          default: m = '0;
        endcase
      end
      K_NEG, K_ABS: begin
        if (s == 0) m = ST_U;
        else if (s == 1) m = ST_S;
      end
      K_CMP: begin
        if (s == 0) m = ST_U;
        else if (s == 1) m = ST_A;
        else if (s == 2) m = ST_R;
      end
      K_DIV: begin
        if (s == 0) m = ST_U;
        else if (s == 1) m = ST_A;
        else if (s == 2) m = ST_R;
        else if (s < 3 + DIV_D_RUN) m = ST_D;
        else if (s == 3 + DIV_D_RUN || s == 5 + DIV_D_RUN) m = ST_D | ST_A;
        else if (s == 4 + DIV_D_RUN || s == 6 + DIV_D_RUN) m = ST_D | ST_R;
        else if (s == 7 + DIV_D_RUN) m = ST_A;
        else if (s == 8 + DIV_D_RUN) m = ST_R;
      end
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/fpx_pattern_gen.sv
module fpx_pattern_gen
  import fpx_issue_pkg::*;
#(
  parameter int DEPTH = PAT_LEN
) (
  input  opk_t                 kind,
  output smask_t [DEPTH-1:0]   pat
);

  for (genvar k = 0; k < DEPTH; k++) begin : g_step
    assign pat[k] = step_mask(kind, k);
  end

endmodule

// File: rtl/fpx_collide.sv
module fpx_collide
  import fpx_issue_pkg::*;
#(
  parameter int DEPTH = PAT_LEN
) (
  input  smask_t [DEPTH-1:0] pat,
  input  smask_t [DEPTH-1:0] ahead,
  output logic               clash
);

  logic [DEPTH-1:0] hit;

  for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
    assign hit[k] = |(pat[k] & ahead[k]);
  end

  assign clash = |hit;

endmodule

// File: rtl/fpx_resv_table.sv
module fpx_resv_table
  import fpx_issue_pkg::*;
#(
  parameter int DEPTH = PAT_LEN
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               merge,
  input  smask_t [DEPTH-1:0] pat,
  output smask_t [DEPTH-1:0] tbl
);

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    smask_t nxt;
    if (k == DEPTH - 1) begin : g_tail
      assign nxt = '0;
    end else begin : g_body
      assign nxt = tbl[k+1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) tbl[k] <= '0;
      else        tbl[k] <= nxt | (merge ? pat[k] : '0);
    end
  end

  // R4: the far end of the table only fills through a merge
  a_r4_tail_only_by_merge: assert property (@(posedge clk) disable iff (!rst_n)
    !merge |=> (tbl[DEPTH-1] == '0));

endmodule

// File: rtl/fpx_stage_issue.sv
module fpx_stage_issue
  import fpx_issue_pkg::*;
#(
  parameter int DEPTH = PAT_LEN
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [2:0] op_kind,
  output logic       op_ready,
  output logic [7:0] stage_busy
);

  opk_t               kind;
  smask_t [DEPTH-1:0] pat;
  smask_t [DEPTH-1:0] tbl;
  smask_t [DEPTH-1:0] ahead;
  logic               clash;
  logic               take;
  logic               real_take;

  assign kind = opk_t'(op_kind);

  // step k of a new op lands k+1 cycles ahead of the current slot
  for (genvar k = 0; k < DEPTH; k++) begin : g_ahead
    if (k == DEPTH - 1) begin : g_tail
      assign ahead[k] = '0;
    end else begin : g_body
      assign ahead[k] = tbl[k+1];
    end
  end

  fpx_pattern_gen #(.DEPTH(DEPTH)) u_pat (
    .kind (kind),
    .pat  (pat)
  );

  fpx_collide #(.DEPTH(DEPTH)) u_cmp (
    .pat   (pat),
    .ahead (ahead),
    .clash (clash)
  );

  assign op_ready = !clash;
  assign take     = op_valid && op_ready;

  fpx_resv_table #(.DEPTH(DEPTH)) u_tbl (
    .clk   (clk),
    .rst_n (rst_n),
    .merge (take),
    .pat   (pat),
    .tbl   (tbl)
  );

  assign stage_busy = tbl[0];

  assign real_take = take && (kind != K_RSV6) && (kind != K_RSV7);

  // R11: producer keeps the offer steady while held off
  a_r11_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |=> (op_valid && $stable(op_kind)));

  // R4: an accepted real op shows its unpack step in the next cycle
  a_r4_unpack_follows_issue: assert property (@(posedge clk) disable iff (!rst_n)
    real_take |=> stage_busy[0]);

  // R10: without a real acceptance the unpack stage stays idle next cycle
  a_r10_no_unpack_without_issue: assert property (@(posedge clk) disable iff (!rst_n)
    !real_take |=> !stage_busy[0]);

  // R3: an empty table never holds an offer back
  a_r3_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl == '0) |-> op_ready);

  // R2: multiply reaches its second multiplier stage six cycles after acceptance
  a_r2_mul_second_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (take && kind == K_MUL) |-> ##6 stage_busy[6]);

endmodule

// File: tb/fpx_stage_issue_test.sv
`timescale 1ns/1ps
module fpx_stage_issue_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [2:0] op_kind;
  logic       op_ready;
  logic [7:0] stage_busy;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int    exp_q[$];
  string req_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fpx_stage_issue uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_kind    (op_kind),
    .op_ready   (op_ready),
    .stage_busy (stage_busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  // driver: offers one op and pushes its expected acceptance cycle
  task automatic send(input logic [2:0] k, input int stall, input string req);
    exp_q.push_back(cyc + stall);
    req_q.push_back(req);
    op_valid = 1'b1;
    op_kind  = k;
    do @(negedge clk); while (!op_ready);
    @(posedge clk);
    #1;
    op_valid = 1'b0;
  endtask

  task automatic expect_busy(input logic [7:0] v, input string req);
    @(negedge clk);
    check(stage_busy == v, req, stage_busy, v);
    @(posedge clk);
    #1;
  endtask

  // monitor: compares each acceptance against the scoreboard
  always @(negedge clk) begin
    if (rst_n && op_valid && op_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected acceptance", cyc, -1);
      end else begin
        int e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(cyc == e, r, cyc, e);
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL R3: watchdog expired at cycle %0d expected finish earlier", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    op_valid = 1'b0;
    op_kind  = 3'd0;
    idle(3);
    rst_n = 1'b1;

    // R1 / R11: idle state, ready for every kind with valid low
    @(negedge clk);
    check(stage_busy == 8'h00, "R1 busy after reset", stage_busy, 0);
    for (int k = 0; k < 8; k++) begin
      op_kind = 3'(k);
      #0.2;
      check(op_ready == 1'b1, "R1 ready after reset", op_ready, 1);
    end
    @(posedge clk);
    #1;

    // R2 / R4: multiply walk through the stages
    send(3'd1, 0, "R4 mul accept");
    expect_busy(8'h01, "R2 mul step0");
    expect_busy(8'h30, "R2 mul step1");
    expect_busy(8'h20, "R2 mul step2");
    expect_busy(8'h20, "R2 mul step3");
    expect_busy(8'h20, "R2 mul step4");
    expect_busy(8'h40, "R2 mul step5");
    expect_busy(8'h44, "R2 mul step6");
    expect_busy(8'h08, "R2 mul step7");
    expect_busy(8'h00, "R4 mul drained");
    idle(40);

    // R4: shift and merge in the same cycle (mul then add next cycle)
    send(3'd1, 0, "R4 mul accept");
    send(3'd0, 0, "R7 add at +1");
    expect_busy(8'h31, "R4 merged step");
    expect_busy(8'h26, "R4 merged step");
    expect_busy(8'h2C, "R4 merged step");
    expect_busy(8'h2A, "R4 merged step");
    expect_busy(8'h40, "R4 merged step");
    idle(40);

    // R5: add after add
    send(3'd0, 0, "R5 first add");
    send(3'd0, 2, "R5 second add");
    idle(40);

    // R6: mul after mul
    send(3'd1, 0, "R6 first mul");
    send(3'd1, 3, "R6 second mul");
    idle(40);

    // R7: add offered at +3, +4, +5 after a multiply
    send(3'd1, 0, "R7 mul");
    idle(2);
    send(3'd0, 0, "R7 add at +3");
    idle(40);
    send(3'd1, 0, "R7 mul");
    idle(3);
    send(3'd0, 2, "R7 add at +4");
    idle(40);
    send(3'd1, 0, "R7 mul");
    idle(4);
    send(3'd0, 1, "R7 add at +5");
    idle(40);

    // R8: short ops back to back, compare after add
    send(3'd2, 0, "R8 neg");
    send(3'd3, 0, "R8 abs after neg");
    send(3'd4, 0, "R8 cmp");
    send(3'd4, 0, "R8 cmp after cmp");
    idle(40);
    send(3'd0, 0, "R8 add");
    send(3'd4, 1, "R8 cmp after add");
    idle(40);

    // R9: divide after divide
    send(3'd5, 0, "R9 first div");
    send(3'd5, 31, "R9 second div");
    idle(40);

    // R10: reserved codes take nothing
    send(3'd6, 0, "R10 code 6 accept");
    expect_busy(8'h00, "R10 code 6 reserves nothing");
    send(3'd1, 0, "R10 mul");
    send(3'd7, 0, "R10 code 7 during mul");
    expect_busy(8'h30, "R10 code 7 reserves nothing");
    idle(40);

    check(exp_q.size() == 0, "R3 all offers accepted", exp_q.size(), 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule